// File: doc/BRIEF.md
# Buffered Four-Channel Input Capture Unit

This block timestamps external events. A 16-bit counter advances by one on every clock. Four capture channels each watch an asynchronous input pin. When the chosen edge arrives on a pin, the channel stores the counter value in its own capture register and raises a status flag. Software reads the captured values over a small register port. A flag is cleared by a handshake: the flag must first be read as 1, and then a 0 is written to its bit.

A buffer option turns channel C into a one-deep history of channel A. Each new A capture first copies the previous A value into C and then stores the new count in A. While this option is on, channel C's own pin is ignored. Channel A then captures on its selected edge. If the edge-select bits of A and C differ, A captures on both edges.

Register map (word addresses): 0 = counter (read/write), 1 = control (read/write), 2 = flag status (read, write-0-to-clear), 8 to 11 = capture registers A to D (read-only).

Top module: `icu_capture4`

## Requirements
- R1: After reset, the counter, the control register, all four capture registers and all flags read 0, and `cap_flag` is 0.
- R2: The counter adds 1 on each clock and wraps from 0xFFFF to 0x0000. A bus write to address 0 loads the written value in place of the increment. Reading address 0 one clock after such a write returns the written value plus 1.
- R3: Suppose a pin change is set up before clock edge n and matches the selected edge. The capture register then holds the counter value that was present between edges n+1 and n+2. The flag rises at edge n+2.
- R4: Control bit i (i = 0..3 for A..D) selects the edge for channel i: 1 means rising and 0 means falling. A pin change in the other direction leaves the capture register and the flag unchanged.
- R5: A capture overwrites the capture register even when that channel's flag is already 1.
- R6: Writing 0 to bit i of address 2 clears flag i only if bit i was read as 1 from address 2 earlier. Writing 0 without that read has no effect. Writing 1 never changes a flag.
- R7: When a capture and a permitted clear hit the same flag on the same clock, the flag stays 1.
- R8: With control bit 8 (buffer enable) set, each A capture moves the old A value into C and the new count into A. This shift does not set flag C. Edges on pin C do not change C or its flag.
- R9: With buffer enable set and control bits 0 and 2 unequal, channel A captures on both rising and falling edges.
- R10: Bus writes to addresses 8 to 11 leave the capture registers unchanged.
- R11: The control register holds bits 0 to 3 and bit 8. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 4 | Asynchronous capture inputs, bit 0 = A .. bit 3 = D |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the address |
| cap_flag | output | 4 | Capture flags, bit 0 = A .. bit 3 = D |

## Verification
A wrong edge detector shows up in two ways. A flag may rise on the opposite pin direction, or the captured value may be one or more counts away from the expected value. This is visible two clocks after the pin change. A corrupted history path in buffer mode shows up as a C value that does not match the A value read just before the capture. A broken arming bit shows up as a flag that clears without a prior read, or that will not clear after one. Both are visible at the next register read.

// File: rtl/icu_pkg.sv
package icu_pkg;
   localparam int ADDR_CNT     = 0;
   localparam int ADDR_CTRL    = 1;
   localparam int ADDR_FLAG    = 2;
   localparam int ADDR_CAP0    = 8;
   localparam int CH_A         = 0;
   localparam int CH_C         = 2;
   localparam int CTRL_BUF_BIT = 8;
endpackage

// File: rtl/icu_sync_edge.sv
module icu_sync_edge #(
   parameter int STAGES  = 2,
   parameter bit RST_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= {STAGES{RST_LVL}};
         last_q <= RST_LVL;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin_async};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise = sh_q[STAGES-1] & ~last_q;
   assign fall = ~sh_q[STAGES-1] & last_q;
endmodule

// File: rtl/icu_frc.sv
module icu_frc #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else            cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/icu_capture_bank.sv
module icu_capture_bank #(
   parameter int W       = 16,
   parameter int NUM_CH  = 4,
   parameter int BUF_SRC = 0,
   parameter int BUF_DST = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          stb,
   input  logic                       buf_en,
   input  logic [W-1:0]               cnt,
   output logic [NUM_CH-1:0][W-1:0]   cap
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [W-1:0] r_q;
      if (i == BUF_DST) begin : g_dst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      r_q <= '0;
            else if (buf_en && stb[BUF_SRC]) r_q <= cap[BUF_SRC];
            else if (!buf_en && stb[i])      r_q <= cnt;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      r_q <= '0;
            else if (stb[i]) r_q <= cnt;
         end
      end
      assign cap[i] = r_q;
   end
endmodule

// File: rtl/icu_flags.sv
module icu_flags #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [NUM_CH-1:0] wr_bits,
   output logic [NUM_CH-1:0] flag
);
   logic [NUM_CH-1:0] armed_q;
   logic [NUM_CH-1:0] clr;

   assign clr = {NUM_CH{wr_stb}} & ~wr_bits & armed_q & flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= '0;
         armed_q <= '0;
      end else begin
         flag    <= set | (flag & ~clr);
         armed_q <= (armed_q | ({NUM_CH{rd_stb}} & flag)) & ~(clr & ~set);
      end
   end
endmodule

// File: rtl/icu_capture4.sv
module icu_capture4 #(
   parameter int DATA_W      = 16,
   parameter int NUM_CH      = 4,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cap_pin,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] cap_flag
);
   import icu_pkg::*;

   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADDR_CNT);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADDR_FLAG);

   if (NUM_CH < 3 || NUM_CH > 8) begin : g_bad_ch
      $error("icu_capture4: NUM_CH must be 3..8");
   end
   if (DATA_W <= CTRL_BUF_BIT) begin : g_bad_w
      $error("icu_capture4: DATA_W too small for control layout");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("icu_capture4: SYNC_STAGES must be at least 2");
   end
   if ((1 << ADDR_W) < ADDR_CAP0 + NUM_CH) begin : g_bad_addr
      $error("icu_capture4: ADDR_W too small for capture window");
   end

   logic                      wr_cnt, wr_ctrl, wr_flag, rd_flag;
   logic [NUM_CH-1:0]         es_q;
   logic                      buf_en;
   logic [NUM_CH-1:0]         rise, fall, stb;
   logic [DATA_W-1:0]         cnt;
   logic [NUM_CH-1:0][DATA_W-1:0] cap;
   logic [NUM_CH-1:0]         flag;

   assign wr_cnt  = bus_sel &  bus_wr & (bus_addr == A_CNT);
   assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == A_CTRL);
   assign wr_flag = bus_sel &  bus_wr & (bus_addr == A_FLAG);
   assign rd_flag = bus_sel & ~bus_wr & (bus_addr == A_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         es_q   <= '0;
         buf_en <= 1'b0;
      end else if (wr_ctrl) begin
         es_q   <= bus_wdata[NUM_CH-1:0];
         buf_en <= bus_wdata[CTRL_BUF_BIT];
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sync
      icu_sync_edge #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_sync (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_async (cap_pin[i]),
         .rise      (rise[i]),
         .fall      (fall[i])
      );
   end

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         stb[i] = es_q[i] ? rise[i] : fall[i];
      end
      if (buf_en) begin
         stb[CH_C] = 1'b0;
         if (es_q[CH_A] != es_q[CH_C]) stb[CH_A] = rise[CH_A] | fall[CH_A];
      end
   end

   icu_frc #(.W(DATA_W)) u_frc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_cnt),
      .load_val (bus_wdata),
      .cnt      (cnt)
   );

   icu_capture_bank #(
      .W(DATA_W), .NUM_CH(NUM_CH), .BUF_SRC(CH_A), .BUF_DST(CH_C)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (stb),
      .buf_en (buf_en),
      .cnt    (cnt),
      .cap    (cap)
   );

   icu_flags #(.NUM_CH(NUM_CH)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (stb),
      .rd_stb  (rd_flag),
      .wr_stb  (wr_flag),
      .wr_bits (bus_wdata[NUM_CH-1:0]),
      .flag    (flag)
   );

   assign cap_flag = flag;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CNT) begin
         bus_rdata = cnt;
      end else if (bus_addr == A_CTRL) begin
         bus_rdata[NUM_CH-1:0]   = es_q;
         bus_rdata[CTRL_BUF_BIT] = buf_en;
      end else if (bus_addr == A_FLAG) begin
         bus_rdata[NUM_CH-1:0] = flag;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(ADDR_CAP0 + i)) bus_rdata = cap[i];
         end
      end
   end
endmodule

// File: rtl/icu_capture4_chk.sv
module icu_capture4_chk #(
   parameter int DATA_W = 16,
   parameter int NUM_CH = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [DATA_W-1:0]             cnt,
   input logic [NUM_CH-1:0][DATA_W-1:0] cap,
   input logic [NUM_CH-1:0]             flag,
   input logic [NUM_CH-1:0]             stb,
   input logic                          buf_en,
   input logic                          wr_cnt,
   input logic                          wr_flag,
   input logic [DATA_W-1:0]             bus_wdata
);
   import icu_pkg::*;

   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> cnt == $past(cnt) + DATA_W'(1));

   assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> cnt == $past(bus_wdata));

   assert_buf_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_en && stb[CH_A] |=> cap[CH_C] == $past(cap[CH_A]));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
         stb[i] |=> flag[i]);

      assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag[i]) |-> $past(wr_flag && !bus_wdata[i]));

      if (i == CH_C) begin : g_c
         assert_cap_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
            stb[i] && !buf_en |=> cap[i] == $past(cnt));
         assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !stb[i] && !(buf_en && stb[CH_A]) |=> $stable(cap[i]));
      end else begin : g_n
         assert_cap_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
            stb[i] |=> cap[i] == $past(cnt));
         assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !stb[i] |=> $stable(cap[i]));
      end
   end
endmodule

bind icu_capture4 icu_capture4_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt       (cnt),
   .cap       (cap),
   .flag      (flag),
   .stb       (stb),
   .buf_en    (buf_en),
   .wr_cnt    (wr_cnt),
   .wr_flag   (wr_flag),
   .bus_wdata (bus_wdata)
);

// File: tb/icu_capture4_tb.sv
`timescale 1ns/1ps
module icu_capture4_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pins = 4'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic [3:0]  cap_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   icu_capture4 u_dut (
      .clk(clk), .rst_n(rst_n), .cap_pin(pins), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cap_flag(cap_flag)
   );

   typedef struct packed {
      logic [15:0] ctrl;
      logic [1:0]  ch;
      logic        from_lvl;
      logic        to_lvl;
      logic [15:0] v;
      logic        hit;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{16'h0000, 2'd0, 1'b0, 1'b1, 16'h1000, 1'b0},
      '{16'h0000, 2'd0, 1'b1, 1'b0, 16'h2000, 1'b1},
      '{16'h0002, 2'd1, 1'b0, 1'b1, 16'h3000, 1'b1},
      '{16'h0002, 2'd1, 1'b1, 1'b0, 16'h4000, 1'b0},
      '{16'h0000, 2'd2, 1'b1, 1'b0, 16'hFFFF, 1'b1},
      '{16'h0008, 2'd3, 1'b0, 1'b1, 16'h5A5A, 1'b1},
      '{16'h0000, 2'd3, 1'b1, 1'b0, 16'h0123, 1'b1},
      '{16'h0004, 2'd2, 1'b0, 1'b1, 16'h7FFE, 1'b1}
   };
   localparam string TAGS [NV] = '{"R4", "R3", "R4", "R4", "R2", "R4", "R3", "R4"};

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // counter preset and pin change in one cycle; capture expected = v + 1
   task automatic strike(input int ch, input logic lvl, input logic [15:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = v;
      pins[ch] = lvl;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] d, pre, prec;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1 check("R1", {12'd0, cap_flag}, 16'h0000);
      bus_read(4'd1, d); check("R1", d, 16'h0000);
      bus_read(4'd2, d); check("R1", d, 16'h0000);
      for (int i = 0; i < 4; i++) begin
         bus_read(4'(8 + i), d); check("R1", d, 16'h0000);
      end

      // table walk: edge selection and captured values
      for (int k = 0; k < NV; k++) begin
         bus_write(4'd1, VECS[k].ctrl);
         pins[VECS[k].ch] = VECS[k].from_lvl;
         settle();
         bus_read(4'(8 + VECS[k].ch), pre);
         strike(int'(VECS[k].ch), VECS[k].to_lvl, VECS[k].v);
         bus_read(4'(8 + VECS[k].ch), d);
         check(TAGS[k], d, VECS[k].hit ? VECS[k].v + 16'd1 : pre);
         if (VECS[k].hit) check(TAGS[k], {15'd0, cap_flag[VECS[k].ch]}, 16'd1);
      end

      // R5 overwrite while flag still set
      bus_write(4'd1, 16'h0002);
      strike(1, 1'b1, 16'h0100);
      bus_read(4'd9, d); check("R5", d, 16'h0101);

      // R6 clear handshake
      bus_write(4'd2, 16'h0000);
      #1 check("R6", {12'd0, cap_flag}, 16'h000F);
      bus_read(4'd2, d); check("R6", d, 16'h000F);
      bus_write(4'd2, 16'h000E);
      #1 check("R6", {12'd0, cap_flag}, 16'h000E);
      bus_write(4'd2, 16'h000F);
      #1 check("R6", {12'd0, cap_flag}, 16'h000E);

      // R7 set beats clear in the same cycle
      bus_write(4'd1, 16'h0001);
      strike(0, 1'b1, 16'h0200);
      bus_read(4'd2, d);
      pins[0] = 1'b0;
      settle();
      @(negedge clk); pins[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 16'h000E;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      #1 check("R7", {15'd0, cap_flag[0]}, 16'd1);

      // R8 buffer shift, C pin ignored
      bus_write(4'd1, 16'h0105);
      bus_write(4'd2, 16'h000B);
      pins[0] = 1'b0;
      settle();
      check("R8", {15'd0, cap_flag[2]}, 16'd0);
      bus_read(4'd8, pre);
      strike(0, 1'b1, 16'h4440);
      bus_read(4'd8, d);  check("R8", d, 16'h4441);
      bus_read(4'd10, d); check("R8", d, pre);
      check("R8", {15'd0, cap_flag[2]}, 16'd0);
      pins[2] = 1'b0; settle();
      pins[2] = 1'b1; settle();
      bus_read(4'd10, d); check("R8", d, pre);
      check("R8", {15'd0, cap_flag[2]}, 16'd0);

      // R9 both edges when select bits differ
      bus_write(4'd1, 16'h0101);
      strike(0, 1'b0, 16'h6000);
      bus_read(4'd8, d);  check("R9", d, 16'h6001);
      bus_read(4'd10, d); check("R9", d, 16'h4441);
      strike(0, 1'b1, 16'h7000);
      bus_read(4'd8, d);  check("R9", d, 16'h7001);
      bus_read(4'd10, prec); check("R9", prec, 16'h6001);

      // R10 capture registers are read-only
      bus_write(4'd8, 16'hDEAD);
      bus_read(4'd8, d); check("R10", d, 16'h7001);

      // R11 control layout
      bus_write(4'd1, 16'hFFFF);
      bus_read(4'd1, d); check("R11", d, 16'h010F);

      // R2 counter load, increment, wrap
      bus_write(4'd0, 16'h1234);
      bus_read(4'd0, d); check("R2", d, 16'h1235);
      bus_write(4'd0, 16'hFFFF);
      bus_read(4'd0, d); check("R2", d, 16'h0000);

      finish_run();
   end
endmodule